// File: doc/BRIEF.md
# Activity-Driven Performance Level Governor

This block picks one of eight discrete performance levels (index 0 for the lowest voltage and frequency, index 7 for the highest) for an engine clock. Once per evaluation interval it receives a one-cycle strobe together with a busy percentage and an estimate of switched power. It turns these into a new level index. A clock and voltage manager outside the block reads the index and applies the matching operating point. Each time the index changes, the block pulses a change strobe for one cycle.

Activity decides the coarse response. A fully idle interval drops the level to the floor. The first busy interval after an idle one jumps the level straight to the highest level that software allows. While activity stays nonzero, seven programmable power thresholds move the level one step at a time, so that it settles at the point where the measured power fits the budget. A hysteresis value on the upward test stops the level from oscillating between two points.

A battery-mode input adds a filter on top of this. In battery mode a move is applied only after the same direction has been requested for a programmable number of consecutive intervals. A cap input bounds every result, including the jump on new activity.

Top module: `perf_governor`

## Requirements
- R1: After reset the level index is 0 and the change strobe is low.
- R2: The level index changes only on a cycle where the evaluation strobe is high. Changes to other inputs between evaluations have no effect on it.
- R3: An evaluation with a busy value of exactly 0 requests level 0.
- R4: An evaluation with nonzero busy requests the highest level (7) when it is the first evaluation after reset or the previous evaluation had busy 0.
- R5: An evaluation with nonzero busy that follows a busy evaluation compares against the 8-bit threshold k, held at bits [8k+7:8k] of the threshold bus for k = 0..6, which marks the boundary between levels k and k+1. If the current level L is above 0 and power > threshold L-1, the request is L-1. Otherwise, if L is below 7 and power + hysteresis < threshold L (computed without overflow), the request is L+1. Otherwise the request is L. The downward test takes priority.
- R6: Every request is limited to the cap input. When the current level is above the cap, the request equals the cap.
- R7: The change strobe is high for exactly the one cycle after an evaluation edge at which the level index took a new value, and is low otherwise.
- R8: With battery mode set, a request that differs from the current level is applied only when it is the N-th consecutive evaluation requesting the same direction, with N = filter length input + 1 (1 to 8). A request equal to the current level, a change of direction, or an applied move restarts the count. The value applied is the request of the evaluation that completes the count.
- R9: With battery mode clear, every request is applied at the evaluation edge and the direction count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evalValid | input | 1 | One-cycle strobe that marks an evaluation interval |
| busyPct | input | 7 | Busy percentage for the interval; only zero and nonzero are distinguished |
| powerEst | input | 8 | Switched-power estimate for the interval |
| batteryMode | input | 1 | Turns on the consecutive-request filter |
| filterLen | input | 3 | Filter length minus one |
| maxLevel | input | 3 | Highest level allowed |
| hysteresis | input | 8 | Margin subtracted from the threshold in the upward test |
| thresholds | input | 56 | Seven packed 8-bit boundary thresholds |
| level | output | 3 | Current performance level index |
| levelChanged | output | 1 | One-cycle pulse after the level changes |

## Verification
The bench drives a long pseudo-random sequence of evaluations against an arithmetic model. The sequence mixes idle and busy intervals, power values on both sides of every threshold, changes of the cap, and battery phases with every filter length. One case it targets is a cap lowered below the current level: a design that only clamps the jump would leave the level stuck above the cap. Another is a direction reversal part-way through a battery streak: a design that does not restart the count would move early, and the bench also catches a move applied one interval late. The threshold tests at levels 0 and 7 and the hysteresis sum near 255 are covered as well; a design that gets them wrong indexes past the table or wraps and steps up falsely. The bench also checks that the strobe does not pulse when a request equals the current level.

// File: rtl/perf_governor_pkg.sv
package perf_governor_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } stepDir_t;

  // Strobes and state handed from control to datapath
  typedef struct packed {
    logic load;      // apply candidate level at this edge
    logic fromIdle;  // previous evaluation was idle (or none since reset)
  } govCtrl_t;
endpackage

// File: rtl/perf_governor_datapath.sv
module perf_governor_datapath
  import perf_governor_pkg::*;
#(
  parameter int NumLevels = 8,
  parameter int PwrW      = 8,
  parameter int BusyW     = 7,
  localparam int LvlW     = $clog2(NumLevels),
  localparam int ThrCnt   = NumLevels - 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [BusyW-1:0]       busyPct,
  input  logic [PwrW-1:0]        powerEst,
  input  logic [LvlW-1:0]        maxLevel,
  input  logic [PwrW-1:0]        hysteresis,
  input  logic [ThrCnt*PwrW-1:0] thresholds,
  input  govCtrl_t               ctrl,
  output stepDir_t               candDir,
  output logic [LvlW-1:0]        level,
  output logic                   levelChanged
);
  localparam logic [LvlW-1:0] TopLevel = LvlW'(NumLevels - 1);

  // Per-level views of the boundary table
  logic [PwrW-1:0] thrDown [NumLevels];
  logic [PwrW-1:0] thrUp   [NumLevels];

  for (genvar k = 0; k < NumLevels; k++) begin : g_thr
    if (k == 0) begin : g_bottom
      assign thrDown[k] = '1;
    end else begin : g_dn
      assign thrDown[k] = thresholds[(k-1)*PwrW +: PwrW];
    end
    if (k == NumLevels - 1) begin : g_top
      assign thrUp[k] = '0;
    end else begin : g_up
      assign thrUp[k] = thresholds[k*PwrW +: PwrW];
    end
  end

  logic            goDown, goUp, busyZero;
  logic [LvlW-1:0] rawLevel, candLevel;
  logic [PwrW:0]   upSum;

  always_comb begin
    busyZero = (busyPct == '0);
    upSum    = {1'b0, powerEst} + {1'b0, hysteresis};
    goDown   = (level != '0) && (powerEst > thrDown[level]);
    goUp     = (level != TopLevel) && (upSum < {1'b0, thrUp[level]});
    if (busyZero)           rawLevel = '0;
    else if (ctrl.fromIdle) rawLevel = TopLevel;
    else if (goDown)        rawLevel = level - 1'b1;
    else if (goUp)          rawLevel = level + 1'b1;
    else                    rawLevel = level;
    candLevel = (rawLevel > maxLevel) ? maxLevel : rawLevel;
    if (candLevel > level)      candDir = DIR_UP;
    else if (candLevel < level) candDir = DIR_DOWN;
    else                        candDir = DIR_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level        <= '0;
      levelChanged <= 1'b0;
    end else begin
      levelChanged <= ctrl.load && (candLevel != level);
      if (ctrl.load) level <= candLevel;
    end
  end

  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(level));

  assert_cap_after_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> level <= $past(maxLevel));

  assert_strobe_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    levelChanged == (level != $past(level)));
endmodule

// File: rtl/perf_governor_control.sv
module perf_governor_control
  import perf_governor_pkg::*;
#(
  parameter int BusyW     = 7,
  parameter int MaxFilter = 8,
  localparam int FlW      = $clog2(MaxFilter),
  localparam int CntW     = $clog2(MaxFilter + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evalValid,
  input  logic [BusyW-1:0] busyPct,
  input  logic             batteryMode,
  input  logic [FlW-1:0]   filterLen,
  input  stepDir_t         candDir,
  output govCtrl_t         ctrl
);
  logic [CntW-1:0] streakCnt, nextCnt;
  stepDir_t        streakDir;
  logic            fromIdle, reach, moveReq;

  always_comb begin
    moveReq = (candDir != DIR_HOLD);
    if (!moveReq)                                    nextCnt = '0;
    else if (candDir == streakDir && streakCnt != 0) nextCnt = streakCnt + 1'b1;
    else                                             nextCnt = CntW'(1);
    reach         = nextCnt >= (CntW'(filterLen) + CntW'(1));
    ctrl.load     = evalValid && moveReq && (!batteryMode || reach);
    ctrl.fromIdle = fromIdle;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fromIdle  <= 1'b1;
      streakCnt <= '0;
      streakDir <= DIR_HOLD;
    end else if (evalValid) begin
      fromIdle <= (busyPct == '0);
      if (!batteryMode || ctrl.load) streakCnt <= '0;
      else                           streakCnt <= nextCnt;
      if (moveReq) streakDir <= candDir;
    end
  end

  assert_immediate_apply_R9: assert property (@(posedge clk) disable iff (!rstN)
    evalValid && !batteryMode && candDir != DIR_HOLD |-> ctrl.load);

  assert_streak_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    streakCnt < CntW'(MaxFilter));

  assert_no_load_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !evalValid |-> !ctrl.load);
endmodule

// File: rtl/perf_governor.sv
module perf_governor
  import perf_governor_pkg::*;
#(
  parameter int NumLevels = 8,
  parameter int PwrW      = 8,
  parameter int BusyW     = 7,
  parameter int MaxFilter = 8,
  localparam int LvlW     = $clog2(NumLevels),
  localparam int FlW      = $clog2(MaxFilter),
  localparam int ThrCnt   = NumLevels - 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   evalValid,
  input  logic [BusyW-1:0]       busyPct,
  input  logic [PwrW-1:0]        powerEst,
  input  logic                   batteryMode,
  input  logic [FlW-1:0]         filterLen,
  input  logic [LvlW-1:0]        maxLevel,
  input  logic [PwrW-1:0]        hysteresis,
  input  logic [ThrCnt*PwrW-1:0] thresholds,
  output logic [LvlW-1:0]        level,
  output logic                   levelChanged
);
  govCtrl_t ctrl;
  stepDir_t candDir;

  perf_governor_control #(.BusyW(BusyW), .MaxFilter(MaxFilter)) u_ctrl (
    .clk(clk), .rstN(rstN), .evalValid(evalValid), .busyPct(busyPct),
    .batteryMode(batteryMode), .filterLen(filterLen), .candDir(candDir),
    .ctrl(ctrl)
  );

  perf_governor_datapath #(.NumLevels(NumLevels), .PwrW(PwrW), .BusyW(BusyW)) u_dp (
    .clk(clk), .rstN(rstN), .busyPct(busyPct), .powerEst(powerEst),
    .maxLevel(maxLevel), .hysteresis(hysteresis), .thresholds(thresholds),
    .ctrl(ctrl), .candDir(candDir), .level(level), .levelChanged(levelChanged)
  );

  assert_idle_floor_R3: assert property (@(posedge clk) disable iff (!rstN)
    evalValid && busyPct == '0 && !batteryMode |=> level == '0);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |=> level == '0 && !levelChanged);
endmodule

// File: tb/perf_governor_tb.sv
module perf_governor_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evalValid = 1'b0;
  logic [6:0]  busyPct = '0;
  logic [7:0]  powerEst = '0;
  logic        batteryMode = 1'b0;
  logic [2:0]  filterLen = '0;
  logic [2:0]  maxLevel = 3'd7;
  logic [7:0]  hysteresis = 8'd10;
  logic [55:0] thresholds;
  logic [2:0]  level;
  logic        levelChanged;

  int checks = 0;
  int errors = 0;

  // Model state
  int mLevel = 0;
  bit mFromIdle = 1'b1;
  int mStreak = 0;
  int mSdir = 0;
  int thr [7];
  logic [31:0] rs = 32'h1234_5678;

  always #5 clk = ~clk;

  perf_governor u_dut (
    .clk(clk), .rstN(rstN), .evalValid(evalValid), .busyPct(busyPct),
    .powerEst(powerEst), .batteryMode(batteryMode), .filterLen(filterLen),
    .maxLevel(maxLevel), .hysteresis(hysteresis), .thresholds(thresholds),
    .level(level), .levelChanged(levelChanged)
  );

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One evaluation; model follows R3..R9, then an idle cycle for R2/R7
  task automatic doEval(input int busy, input int pwr);
    int req, dir, oldLevel;
    string tag;
    bit apply;
    @(negedge clk);
    busyPct = 7'(busy);
    powerEst = 8'(pwr);
    evalValid = 1'b1;
    oldLevel = mLevel;
    if (busy == 0) begin req = 0; tag = "R3"; end
    else if (mFromIdle) begin req = 7; tag = "R4"; end
    else if (mLevel > 0 && pwr > thr[mLevel-1]) begin req = mLevel - 1; tag = "R5"; end
    else if (mLevel < 7 && pwr + int'(hysteresis) < thr[mLevel]) begin req = mLevel + 1; tag = "R5"; end
    else begin req = mLevel; tag = "R5"; end
    if (req > int'(maxLevel)) begin req = int'(maxLevel); tag = "R6"; end
    dir = (req > mLevel) ? 1 : (req < mLevel) ? -1 : 0;
    apply = 1'b0;
    if (batteryMode) begin
      tag = "R8";
      if (dir == 0) mStreak = 0;
      else if (dir == mSdir && mStreak != 0) mStreak++;
      else mStreak = 1;
      if (dir != 0) mSdir = dir;
      if (dir != 0 && mStreak >= int'(filterLen) + 1) begin apply = 1'b1; mStreak = 0; end
    end else begin
      // R9: applied immediately
      mStreak = 0;
      if (dir != 0) begin apply = 1'b1; mSdir = dir; end
    end
    if (apply) mLevel = req;
    mFromIdle = (busy == 0);
    @(negedge clk);
    evalValid = 1'b0;
    check(tag, int'(level), mLevel);
    check("R7 strobe", int'(levelChanged), int'(mLevel != oldLevel));
    // idle cycle with disturbing inputs: R2 level held, R7 strobe gone
    rs = nextRand(rs);
    busyPct = rs[6:0];
    powerEst = rs[15:8];
    @(negedge clk);
    check("R2 hold", int'(level), mLevel);
    check("R7 pulse width", int'(levelChanged), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 7; k++) begin
      thr[k] = 200 - 25 * k;
      thresholds[k*8 +: 8] = 8'(200 - 25 * k);
    end
    repeat (3) @(negedge clk);
    check("R1 level", int'(level), 0);
    check("R1 strobe", int'(levelChanged), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 level", int'(level), 0);
    // Directed: idle at floor, jump, step, idle drop
    doEval(0, 100);         // R3 stays 0, no strobe
    doEval(50, 100);        // R4 jump to 7
    doEval(50, 100);        // R5 step down (100 > 50)
    doEval(50, 255);        // R5 down again
    doEval(0, 0);           // R3 drop to 0
    maxLevel = 3'd4;
    doEval(30, 0);          // R4 jump limited by cap (R6)
    doEval(30, 0);          // R5 up request clamped, hold
    maxLevel = 3'd2;
    doEval(30, 0);          // R6 level above cap drops to cap
    maxLevel = 3'd7;
    hysteresis = 8'd250;
    doEval(30, 20);         // R5 hysteresis sum above 255, no wrap, hold
    hysteresis = 8'd10;
    // Battery mode with a short directed streak
    batteryMode = 1'b1;
    filterLen = 3'd2;
    doEval(30, 0);          // R8 up 1 of 3
    doEval(30, 0);          // R8 up 2 of 3
    doEval(30, 255);        // R8 reversal restarts
    doEval(30, 0);
    doEval(30, 0);
    doEval(30, 0);          // R8 third consecutive up applies
    batteryMode = 1'b0;
    // Pseudo-random sweep across all filter lengths and caps
    for (int n = 0; n < 3000; n++) begin
      int b, p;
      rs = nextRand(rs);
      if (n % 150 == 0) begin
        batteryMode = rs[20];
        filterLen = 3'((n / 150) % 8);
      end
      if (rs[31:28] == 4'd0) maxLevel = rs[26:24];
      if (rs[31:28] == 4'd1) maxLevel = 3'd7;
      b = (rs[2:0] == 3'd0) ? 0 : int'(rs[9:3]) % 100 + 1;
      p = int'(rs[17:10]);
      doEval(b, p);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule